// File: doc/BRIEF.md
# Modular-Feedback Shift Register Core for a Word Stream Cipher

This block is the state register and feedback path of a word-oriented stream cipher. It keeps sixteen 31-bit cells. On each advance the cells move down by one position and a new top cell enters. The new value is a weighted sum of five cells, reduced modulo the prime 2^31−1. During initialization, the upper 31 bits of a 32-bit word from the nonlinear stage are added into that sum. In working mode that word has no effect.

The feedback sum uses a tree of 31-bit carry-save adders. Each carry vector is rotated left by one bit, because 2^31 is congruent to 1 modulo the prime. A single end-around-carry adder then resolves the result. A load strobe fills all cells from a 128-bit key, a 128-bit IV and sixteen fixed 15-bit constants. Four 32-bit words are assembled from cell halves and presented every cycle: three of them feed the nonlinear function and one feeds keystream generation.

Top module: `mfsr_core`

## Requirements
- R1: While `rst_n` is low, and after its release until the first load or advance, every cell is zero and `x0`..`x3` all read zero.
- R2: When `load` is high at a clock edge, cell i (i = 0..15) becomes {key[127-8i -: 8], C_i, iv[127-8i -: 8]}. Here C_0..C_15 are 15'h44D7, 26BC, 626B, 135E, 5789, 35E2, 7135, 09AF, 4D78, 2F13, 6BC4, 1AF1, 5E26, 3C4D, 789A, 47AC. `load` overrides `step`.
- R3: The output words are x0 = {S15[30:15], S14[15:0]}, x1 = {S11[15:0], S9[30:15]}, x2 = {S7[15:0], S5[30:15]} and x3 = {S2[15:0], S0[30:15]}. They are read from the current cells.
- R4: When `step` is high and `load` is low, each cell i takes the old value of cell i+1. Cell 15 takes t = 2^15·S15 + 2^17·S13 + 2^21·S10 + 2^20·S4 + (1+2^8)·S0 mod 2^31−1.
- R5: With `init_mode` high, the new top cell is (t + w_in[31:1]) mod 2^31−1, and w_in[0] has no effect. With `init_mode` low, w_in has no effect at all.
- R6: A new top value that is congruent to zero is stored as 2^31−1 (all ones), never as 0.
- R7: With both `step` and `load` low, the cells and outputs hold their values.
- R8: With `step` held high, the register advances on every clock edge, so a new set of words appears every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Fill the cells from key, IV and constants |
| key | input | 128 | Key; byte 0 is bits 127:120 |
| iv | input | 128 | Initial vector; byte 0 is bits 127:120 |
| step | input | 1 | Advance the register by one cell |
| init_mode | input | 1 | Add w_in[31:1] into the feedback |
| w_in | input | 32 | Nonlinear-stage word used during initialization |
| x0 | output | 32 | Reorganized word from S15 and S14 |
| x1 | output | 32 | Reorganized word from S11 and S9 |
| x2 | output | 32 | Reorganized word from S7 and S5 |
| x3 | output | 32 | Reorganized word from S2 and S0 |

## Verification
The new top cell appears in the upper half of `x0` one cycle after the advance that created it. A wrong weight, a missed carry rotation or a missing end-around carry therefore shows up on the very next cycle. The same value then passes through `x1`, `x2` and `x3` as it moves down the register, so each corrupted cell is seen several more times. A fault in the load mapping shows on the load cycle in all four words. A fault in the zero substitution appears only when the sum is congruent to zero, so the bench builds such a case on purpose through w_in.

// File: rtl/mfsr_core.sv
module mfsr_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [127:0] key,
  input  logic [127:0] iv,
  input  logic         step,
  input  logic         init_mode,
  input  logic [31:0]  w_in,
  output logic [31:0]  x0,
  output logic [31:0]  x1,
  output logic [31:0]  x2,
  output logic [31:0]  x3
);
  localparam int CW = 31;
  localparam int NC = 16;
  localparam logic [CW-1:0] PRIME = {CW{1'b1}};
  localparam logic [15*NC-1:0] CONSTS = {
    15'h44D7, 15'h26BC, 15'h626B, 15'h135E, 15'h5789, 15'h35E2, 15'h7135, 15'h09AF,
    15'h4D78, 15'h2F13, 15'h6BC4, 15'h1AF1, 15'h5E26, 15'h3C4D, 15'h789A, 15'h47AC};

  logic [CW-1:0] s [NC];

  function automatic logic [CW-1:0] rotl(input logic [CW-1:0] a, input int k);
    return (a << k) | (a >> (CW - k));
  endfunction

  function automatic logic [CW-1:0] maj_rot(input logic [CW-1:0] a, b, c);
    return rotl((a & b) | (a & c) | (b & c), 1);
  endfunction

  logic [CW-1:0] op_a, op_b, op_c, op_d, op_e, op_f, op_w;
  assign op_a = rotl(s[15], 15);
  assign op_b = rotl(s[13], 17);
  assign op_c = rotl(s[10], 21);
  assign op_d = rotl(s[4], 20);
  assign op_e = rotl(s[0], 8);
  assign op_f = s[0];
  assign op_w = init_mode ? w_in[31:1] : '0;

  logic unused_w0;
  assign unused_w0 = w_in[0];

  logic [CW-1:0] s1a, c1a, s1b, c1b, s2, c2, s3, c3, s4, c4;
  assign s1a = op_a ^ op_b ^ op_c;
  assign c1a = maj_rot(op_a, op_b, op_c);
  assign s1b = op_d ^ op_e ^ op_f;
  assign c1b = maj_rot(op_d, op_e, op_f);
  assign s2  = s1a ^ c1a ^ s1b;
  assign c2  = maj_rot(s1a, c1a, s1b);
  assign s3  = s2 ^ c2 ^ c1b;
  assign c3  = maj_rot(s2, c2, c1b);
  assign s4  = s3 ^ c3 ^ op_w;
  assign c4  = maj_rot(s3, c3, op_w);

  logic [CW:0]   raw_sum;
  logic [CW-1:0] folded, top_next;
  assign raw_sum  = {1'b0, s4} + {1'b0, c4};
  assign folded   = raw_sum[CW-1:0] + {{(CW-1){1'b0}}, raw_sum[CW]};
  assign top_next = (folded == '0) ? PRIME : folded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) s[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NC; i++)
        s[i] <= {key[127-8*i -: 8], CONSTS[15*NC-1-15*i -: 15], iv[127-8*i -: 8]};
    end else if (step) begin
      for (int i = 0; i < NC-1; i++) s[i] <= s[i+1];
      s[NC-1] <= top_next;
    end
  end

  assign x0 = {s[15][30:15], s[14][15:0]};
  assign x1 = {s[11][15:0], s[9][30:15]};
  assign x2 = {s[7][15:0], s[5][30:15]};
  assign x3 = {s[2][15:0], s[0][30:15]};

  // R6
  top_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (s[15] != '0));

  // R4
  shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (s[14] == $past(s[15]) && s[0] == $past(s[1])));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(x0) && $stable(x1) && $stable(x2) && $stable(x3)));

  // R2
  load_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (s[15][30:23] == $past(key[7:0]) && s[0][7:0] == $past(iv[127:120])));
endmodule

// File: tb/mfsr_core_bench.sv
module mfsr_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint P = 64'h7FFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, step = 1'b0, init_mode = 1'b0;
  logic [127:0] key = '0, iv = '0;
  logic [31:0] w_in = '0;
  logic [31:0] x0, x1, x2, x3;

  mfsr_core u_mfsr_core (.clk(clk), .rst_n(rst_n), .load(load), .key(key), .iv(iv),
    .step(step), .init_mode(init_mode), .w_in(w_in), .x0(x0), .x1(x1), .x2(x2), .x3(x3));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  logic [127:0] exp_q[$];
  string tag_q[$];
  logic [30:0] m [16];
  logic [14:0] kc [16] = '{15'h44D7, 15'h26BC, 15'h626B, 15'h135E, 15'h5789, 15'h35E2,
    15'h7135, 15'h09AF, 15'h4D78, 15'h2F13, 15'h6BC4, 15'h1AF1, 15'h5E26, 15'h3C4D,
    15'h789A, 15'h47AC};

  function automatic logic [127:0] model_words();
    return {m[15][30:15], m[14][15:0], m[11][15:0], m[9][30:15],
            m[7][15:0], m[5][30:15], m[2][15:0], m[0][30:15]};
  endfunction

  function automatic longint model_sum();
    longint acc;
    acc = ((longint'(m[15]) << 15) % P) + ((longint'(m[13]) << 17) % P)
        + ((longint'(m[10]) << 21) % P) + ((longint'(m[4]) << 20) % P)
        + ((longint'(m[0]) << 8) % P) + longint'(m[0]);
    return acc % P;
  endfunction

  task automatic model_step(input logic ini, input logic [31:0] w);
    longint acc;
    acc = model_sum();
    if (ini) acc = (acc + longint'(w[31:1])) % P;
    if (acc == 0) acc = P;
    for (int i = 0; i < 15; i++) m[i] = m[i+1];
    m[15] = acc[30:0];
  endtask

  task automatic drive(input logic ld, input logic [127:0] k, input logic [127:0] v,
                       input logic st, input logic ini, input logic [31:0] w, input string tag);
    @(negedge clk);
    load = ld; key = k; iv = v; step = st; init_mode = ini; w_in = w;
    if (ld) begin
      for (int i = 0; i < 16; i++) m[i] = {k[127-8*i -: 8], kc[i], v[127-8*i -: 8]};
    end else if (st) model_step(ini, w);
    exp_q.push_back(model_words());
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [127:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({x0, x1, x2, x3} !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, {x0, x1, x2, x3}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] k1, v1, k2, v2;
    longint need;
    repeat (3) @(negedge clk);
    checks++;
    if ({x0, x1, x2, x3} !== '0) begin
      failures++;
      $display("FAIL R1 actual=%h expected=0", {x0, x1, x2, x3});
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({x0, x1, x2, x3} !== '0) begin
      failures++;
      $display("FAIL R1 actual=%h expected=0", {x0, x1, x2, x3});
    end
    k1 = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    v1 = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
    k2 = {$urandom(), $urandom(), $urandom(), $urandom()};
    v2 = {$urandom(), $urandom(), $urandom(), $urandom()};
    // R2 R3: load with step also high, load must win
    drive(1'b1, k1, v1, 1'b1, 1'b1, 32'hDEAD_BEEF, "R2/R3 load");
    // R5: initialization with varied W, including odd values (bit 0 ignored)
    for (int j = 0; j < 32; j++)
      drive(1'b0, k1, v1, 1'b1, 1'b1, $urandom(), "R5 init step");
    // R6: pick W so the new top is congruent to zero
    need = (P - model_sum()) % P;
    drive(1'b0, k1, v1, 1'b1, 1'b1, {need[30:0], 1'b1}, "R6 zero substitution");
    // R7: hold with noise on W and init_mode
    for (int j = 0; j < 4; j++)
      drive(1'b0, k1, v1, 1'b0, j[0], $urandom(), "R7 hold");
    // R4 R5 R8: continuous working mode, W must be ignored
    for (int j = 0; j < 48; j++)
      drive(1'b0, k1, v1, 1'b1, 1'b0, $urandom(), "R4/R8 working step");
    // R2 reload mid-stream, then more steps
    drive(1'b1, k2, v2, 1'b0, 1'b0, 32'h0, "R2 reload");
    for (int j = 0; j < 20; j++)
      drive(1'b0, k2, v2, 1'b1, j < 10, $urandom(), "R4/R5 after reload");
    drive(1'b1, '0, '0, 1'b0, 1'b0, 32'h0, "R2 zero key");
    need = (P - model_sum()) % P;
    drive(1'b0, '0, '0, 1'b1, 1'b1, {need[30:0], 1'b0}, "R6 zero after zero key");
    for (int j = 0; j < 8; j++)
      drive(1'b0, '0, '0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R4 working after zero key");
    drive(1'b0, '0, '0, 1'b0, 1'b0, 32'h0, "R7 final hold");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule